// File: doc/BRIEF.md
# Device Interrupt Routing Table

This block holds one routing entry per interrupt source, selected by the source's device number. Software fills the entries through a 64-bit register port: each entry occupies one doubleword in a small address window. Within an entry, a 6-bit field names the hardware thread that should take the interrupt, and a second 6-bit field gives the vector that thread receives.

When a source raises a request, it presents its device number. The block reads that device's entry and checks a 64-bit mask of threads that are currently present. One cycle later it reports the result. If the target thread is present, the result is an acknowledge and the block emits a single-cycle dispatch pulse carrying the thread and vector. If the thread is absent, the result is a negative acknowledge and no dispatch is issued.

The result also classifies the source. A few device numbers are set aside for particular kinds of source: one for memory error reports, one for the serial interface, and the upper half of the range for the network unit. The result stays on the outputs until the next request is accepted.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry reads as zero, and res_valid, res_ack, res_nack and disp_pulse are all low.
- R2: A register access hits the table when address bits [2:0] are zero and bits [19:10] are zero. Bits [9:3] then select the entry. A hitting write stores all 64 data bits, and a hitting read returns the stored entry combinationally with csr_hit high.
- R3: An access that does not hit leaves csr_hit low. A write that misses changes no entry, and a read that misses returns zero.
- R4: A hitting write that sets any bit outside [13:8] and [5:0] raises csr_rsvd_wr for exactly one cycle, on the cycle after the write. The whole value is still stored.
- R5: On the cycle after irq_valid is sampled high, res_valid is high. res_thread then equals bits [13:8] of the entry for irq_dev, and res_vector equals bits [5:0] of that entry.
- R6: If thread_present has the target thread's bit set when the request is accepted, res_ack is high, res_code is 8'h00, and disp_pulse is high for exactly one cycle.
- R7: If the target thread's bit is clear, res_nack is high, res_code is 8'hFF, and disp_pulse stays low.
- R8: res_class is 2'd1 for device 1, 2'd2 for device 2, 2'd3 for devices 64 to 127, and 2'd0 for all other devices.
- R9: The result is held unchanged until the next request, even if thread_present changes in between. Requests on consecutive cycles each produce their own result one cycle later.
- R10: When a request and a write to the same entry fall in the same cycle, the lookup uses the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Register access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 20 | Byte offset of the access |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data (combinational) |
| csr_hit | output | 1 | Access falls in the table window |
| csr_rsvd_wr | output | 1 | Write touched bits outside the used fields |
| thread_present | input | 64 | One bit per thread, set when the thread exists |
| irq_valid | input | 1 | Interrupt request |
| irq_dev | input | 7 | Device number of the request |
| res_valid | output | 1 | A result is being held |
| res_ack | output | 1 | Target present, dispatched |
| res_nack | output | 1 | Target absent, not dispatched |
| res_code | output | 8 | 8'h00 for an acknowledge, 8'hFF for a negative acknowledge |
| res_thread | output | 6 | Target thread of the held result |
| res_vector | output | 6 | Vector of the held result |
| res_class | output | 2 | Source class of the held result |
| disp_pulse | output | 1 | Single-cycle dispatch to res_thread |

## Verification
The hardest situation to reach from the ports is a request that lands in the same cycle as a rewrite of its own entry. If that timing is off by one cycle, the test silently checks the ordinary path instead. To reach it, the bench drives the write strobe and the request on the same clock low phase, with the same device number. It then expects the old thread and vector, and it issues a second request to confirm that the new value was stored. The bench also changes the thread mask between requests, which shows that the held result is a snapshot and does not follow the live mask.

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int DEV_COUNT = 128,
  parameter int THREADS   = 64,
  parameter int VEC_W     = 6,
  parameter int TID_LSB   = 8,
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 64,
  parameter int CODE_W    = 8,
  parameter int ERR_DEV   = 1,
  parameter int SER_DEV   = 2,
  parameter int NET_LO    = 64,
  localparam int DEV_W    = $clog2(DEV_COUNT),
  localparam int TID_W    = $clog2(THREADS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic              csr_write,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_hit,
  output logic              csr_rsvd_wr,
  input  logic [THREADS-1:0] thread_present,
  input  logic              irq_valid,
  input  logic [DEV_W-1:0]  irq_dev,
  output logic              res_valid,
  output logic              res_ack,
  output logic              res_nack,
  output logic [CODE_W-1:0] res_code,
  output logic [TID_W-1:0]  res_thread,
  output logic [VEC_W-1:0]  res_vector,
  output logic [1:0]        res_class,
  output logic              disp_pulse
);
  localparam int WIN_LSB = 3;
  localparam int WIN_MSB = WIN_LSB + DEV_W;
  localparam logic [DATA_W-1:0] USED_MASK =
    ({{(DATA_W-TID_W){1'b0}}, {TID_W{1'b1}}} << TID_LSB) |
     {{(DATA_W-VEC_W){1'b0}}, {VEC_W{1'b1}}};

  logic [DATA_W-1:0] tbl [DEV_COUNT];

  logic             in_win;
  logic [DEV_W-1:0] csr_idx;
  logic             wr_en;
  logic [TID_W-1:0] look_tid;
  logic [VEC_W-1:0] look_vec;
  logic             look_present;
  logic [1:0]       look_class;

  assign in_win  = (csr_addr[ADDR_W-1:WIN_MSB] == '0) && (csr_addr[WIN_LSB-1:0] == '0);
  assign csr_idx = csr_addr[WIN_MSB-1:WIN_LSB];
  assign csr_hit = csr_valid && in_win;
  assign wr_en   = csr_hit && csr_write;
  assign csr_rdata = (csr_hit && !csr_write) ? tbl[csr_idx] : '0;

  assign look_tid     = tbl[irq_dev][TID_LSB +: TID_W];
  assign look_vec     = tbl[irq_dev][VEC_W-1:0];
  assign look_present = thread_present[look_tid];

  always_comb begin
    if (int'(irq_dev) == ERR_DEV)      look_class = 2'd1;
    else if (int'(irq_dev) == SER_DEV) look_class = 2'd2;
    else if (int'(irq_dev) >= NET_LO)  look_class = 2'd3;
    else                               look_class = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEV_COUNT; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[csr_idx] <= csr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_rsvd_wr <= 1'b0;
    else        csr_rsvd_wr <= wr_en && ((csr_wdata & ~USED_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_ack    <= 1'b0;
      res_nack   <= 1'b0;
      res_thread <= '0;
      res_vector <= '0;
      res_class  <= 2'd0;
      disp_pulse <= 1'b0;
    end else begin
      disp_pulse <= irq_valid && look_present;
      if (irq_valid) begin
        res_valid  <= 1'b1;
        res_ack    <= look_present;
        res_nack   <= !look_present;
        res_thread <= look_tid;
        res_vector <= look_vec;
        res_class  <= look_class;
      end
    end
  end

  assign res_code = res_nack ? {CODE_W{1'b1}} : '0;
endmodule

module irq_route_table_chk #(
  parameter int CODE_W = 8,
  parameter int TID_W  = 6,
  parameter int VEC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_valid,
  input logic              csr_write,
  input logic              csr_rsvd_wr,
  input logic              irq_valid,
  input logic              res_valid,
  input logic              res_ack,
  input logic              res_nack,
  input logic [CODE_W-1:0] res_code,
  input logic [TID_W-1:0]  res_thread,
  input logic [VEC_W-1:0]  res_vector,
  input logic              disp_pulse
);
  a_r4_rsvd_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rsvd_wr |-> $past(csr_valid && csr_write));
  a_r5_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> res_valid && (res_ack != res_nack));
  a_r6_pulse_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    disp_pulse |-> res_ack && res_code == '0);
  a_r7_nack_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_nack |-> !disp_pulse && res_code == {CODE_W{1'b1}});
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |=> !disp_pulse && $stable(res_ack) && $stable(res_thread) && $stable(res_vector));
endmodule

bind irq_route_table irq_route_table_chk #(.CODE_W(CODE_W), .TID_W(TID_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
  .csr_rsvd_wr(csr_rsvd_wr), .irq_valid(irq_valid), .res_valid(res_valid),
  .res_ack(res_ack), .res_nack(res_nack), .res_code(res_code),
  .res_thread(res_thread), .res_vector(res_vector), .disp_pulse(disp_pulse));

// File: tb/irq_route_table_test.sv
module irq_route_table_test;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 0, rst_n = 0;
  logic        csr_valid = 0, csr_write = 0;
  logic [19:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0, csr_rdata;
  logic        csr_hit, csr_rsvd_wr;
  logic [63:0] thread_present = '0;
  logic        irq_valid = 0;
  logic [6:0]  irq_dev = '0;
  logic        res_valid, res_ack, res_nack, disp_pulse;
  logic [7:0]  res_code;
  logic [5:0]  res_thread, res_vector;
  logic [1:0]  res_class;
  int checks = 0, failures = 0;
  bit done = 0;

  irq_route_table uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(int tid, int vec);
    return (64'(tid) << 8) | 64'(vec);
  endfunction

  task automatic csr_wr(logic [19:0] a, logic [63:0] d);
    @(negedge clk); csr_valid = 1; csr_write = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_valid = 0; csr_write = 0;
  endtask

  task automatic csr_rd(logic [19:0] a, output logic [63:0] d, output logic h);
    @(negedge clk); csr_valid = 1; csr_write = 0; csr_addr = a;
    #1 d = csr_rdata; h = csr_hit;
    csr_valid = 0;
  endtask

  task automatic irq(logic [6:0] dev);
    @(negedge clk); irq_valid = 1; irq_dev = dev;
    @(negedge clk); irq_valid = 0;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic h;
    check("R1 res_valid", res_valid, 0);
    check("R1 ack/nack", {res_ack, res_nack}, 0);
    check("R1 disp", disp_pulse, 0);
    csr_rd(20'h3F8, d, h);
    check("R1 entry zero", d, 0);
  endtask

  task automatic t_csr;
    logic [63:0] d; logic h;
    csr_wr(20'h018, ent(5, 33));
    csr_rd(20'h018, d, h);
    check("R2 readback", d, ent(5, 33));
    check("R2 hit", h, 1);
    csr_wr(20'h01C, 64'hFFFF);
    csr_wr(20'h40018, 64'hFFFF);
    csr_rd(20'h018, d, h);
    check("R3 miss write ignored", d, ent(5, 33));
    csr_rd(20'h01C, d, h);
    check("R3 misaligned read zero", d, 0);
    check("R3 misaligned no hit", h, 0);
    csr_rd(20'h00400, d, h);
    check("R3 outside window no hit", h, 0);
  endtask

  task automatic t_rsvd;
    logic [63:0] d; logic h;
    csr_wr(20'h020, ent(63, 63));
    check("R4 clean write no flag", csr_rsvd_wr, 0);
    csr_wr(20'h028, 64'h8000_0000_0000_0A05);
    check("R4 flag raised", csr_rsvd_wr, 1);
    @(negedge clk);
    check("R4 flag one cycle", csr_rsvd_wr, 0);
    csr_rd(20'h028, d, h);
    check("R4 stored as given", d, 64'h8000_0000_0000_0A05);
    csr_wr(20'h028, 64'h40);
    check("R4 bit6 flagged", csr_rsvd_wr, 1);
  endtask

  task automatic t_ack;
    thread_present = 64'h0000_0000_0000_0030;
    csr_wr(20'h200, ent(5, 17));
    irq(7'd64);
    check("R5 res_valid", res_valid, 1);
    check("R5 thread", res_thread, 5);
    check("R5 vector", res_vector, 17);
    check("R6 ack", {res_ack, res_nack}, 2'b10);
    check("R6 code", res_code, 8'h00);
    check("R6 pulse", disp_pulse, 1);
    check("R8 network class", res_class, 3);
    @(negedge clk);
    check("R6 pulse one cycle", disp_pulse, 0);
  endtask

  task automatic t_nack;
    csr_wr(20'h008, ent(10, 2));
    irq(7'd1);
    check("R7 nack", {res_ack, res_nack}, 2'b01);
    check("R7 code", res_code, 8'hFF);
    check("R7 no pulse", disp_pulse, 0);
    check("R7 thread", res_thread, 10);
    check("R8 error class", res_class, 1);
    irq(7'd2);
    check("R8 serial class", res_class, 2);
    irq(7'd63);
    check("R8 ordinary class", res_class, 0);
  endtask

  task automatic t_hold;
    irq(7'd64);
    thread_present = '0;
    repeat (3) @(negedge clk);
    check("R9 held ack", res_ack, 1);
    check("R9 held thread", res_thread, 5);
    check("R9 no pulse", disp_pulse, 0);
    thread_present = 64'h20;
    @(negedge clk); irq_valid = 1; irq_dev = 7'd64;
    @(negedge clk); irq_dev = 7'd1;
    check("R9 first of pair", res_ack, 1);
    check("R9 first pulse", disp_pulse, 1);
    @(negedge clk); irq_valid = 0;
    check("R9 second of pair", {res_nack, res_thread}, {1'b1, 6'd10});
    check("R9 second no pulse", disp_pulse, 0);
  endtask

  task automatic t_collide;
    thread_present = 64'h18;
    csr_wr(20'h028, ent(3, 7));
    @(negedge clk);
    csr_valid = 1; csr_write = 1; csr_addr = 20'h028; csr_wdata = ent(4, 9);
    irq_valid = 1; irq_dev = 7'd5;
    @(negedge clk);
    csr_valid = 0; csr_write = 0; irq_valid = 0;
    check("R10 old thread", res_thread, 3);
    check("R10 old vector", res_vector, 7);
    irq(7'd5);
    check("R10 new value after", {res_thread, res_vector}, {6'd4, 6'd9});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_csr();
    t_rsvd();
    t_ack();
    t_nack();
    t_hold();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule